// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller sits between a synchronous request port and an external asynchronous static RAM. The RAM has 18 address bits (262,144 locations) and one byte per location on a shared bidirectional data bus. One request carries a direction, an address and, for stores, a data byte. The controller turns it into a sequence of active-low chip-select, read-strobe and write-strobe levels that spans several system clocks. The lengths of the read window, the write pulse and the bus turnaround gap are whole clock counts set by parameters. This lets the memory's access-time and pulse-width minimums be met at the chosen clock rate.

The data bus is brought out as three signals: a driven value, a driver enable and a sampled value. The pad ring combines them into the real tri-state pin. For a write, the controller keeps the read strobe inactive and turns its driver on one cycle before the write strobe falls. It turns the driver off one cycle after the strobe rises. As a result, the controller and the memory never drive the bus at the same time. The address changes only while every strobe is inactive. Load data is captured on the last clock of the read window and returned with a one-cycle valid pulse.

A new request is taken only when the ready output is high. That happens only when the controller is idle. Requests offered while it is busy have no effect.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and on release, chip select, read strobe and write strobe are high, the data driver is off, ready is high and the load-valid pulse is low. Reset acts at once, even in the middle of an access.
- R2: The memory address changes only on the cycle a request is accepted. It is held constant whenever chip select is low. The cycle after acceptance always has every strobe high.
- R3: A read holds chip select and read strobe low together for exactly RD_CYC consecutive cycles, with the write strobe high and the driver off.
- R4: Load data equals the bus value in the last cycle of the read window. It appears with load-valid high for exactly one cycle: the cycle right after the read window, RD_CYC+2 cycles after acceptance.
- R5: A write keeps the read strobe high throughout. The driver is on for exactly WR_CYC+2 cycles. The write strobe is low for exactly WR_CYC cycles inside that span, with one driver cycle before it and one after it. The driven value is the request's byte, which the memory then holds.
- R6: The write strobe is never low unless chip select is low. The driver is never on while the read strobe is low.
- R7: Ready is high only when idle. A request offered while ready is low starts no access and leaves memory unchanged.
- R8: After every access, TURN_CYC cycles with all strobes high and the driver off pass before ready returns. A read keeps ready low for RD_CYC+TURN_CYC+1 cycles, a write for WR_CYC+TURN_CYC+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store byte |
| req_ready | output | 1 | Idle, request will be taken |
| rd_data | output | DATA_W | Captured load byte |
| rd_valid | output | 1 | One-cycle load-data strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Value driven onto the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | DATA_W | Value sampled from the bus |

## Verification
A sequencer stuck in the wrong phase or with a miscounted window shows up at the ports within the same access. The strobe low-time counts, the busy length, or the cycle in which load-valid appears differ from the parameters on the very transaction where the fault happens. An early driver enable or a late release is caught on its own cycle by the bus-contention check in the behavioural memory. A wrong capture point or a write that does not land shows up as a mismatched byte on the next read of that address.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 3,
  parameter int WR_CYC   = 3,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_A = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_C = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ASET, S_READ, S_WSET, S_WPUL, S_WHLD, S_GAP
  } phase_t;

  phase_t            st, st_nx;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last_rd, last_wr, last_gap;

  assign last_rd  = (cnt == CNT_W'(RD_CYC - 1));
  assign last_wr  = (cnt == CNT_W'(WR_CYC - 1));
  assign last_gap = (cnt == CNT_W'(TURN_CYC - 1));

  always_comb begin
    st_nx  = st;
    cnt_nx = '0;
    unique case (st)
      S_IDLE: if (req_valid) st_nx = S_ASET;
      S_ASET: st_nx = wr_q ? S_WSET : S_READ;
      S_READ: if (last_rd) st_nx = S_GAP; else cnt_nx = cnt + 1'b1;
      S_WSET: st_nx = S_WPUL;
      S_WPUL: if (last_wr) st_nx = S_WHLD; else cnt_nx = cnt + 1'b1;
      S_WHLD: st_nx = S_GAP;
      S_GAP:  if (last_gap) st_nx = S_IDLE; else cnt_nx = cnt + 1'b1;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      rd_valid  <= (st == S_READ) && last_rd;
      if (st == S_READ && last_rd) rd_data <= mem_dq_in;
      if (st == S_IDLE && req_valid) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      mem_ce_n  <= !(st_nx inside {S_READ, S_WSET, S_WPUL, S_WHLD});
      mem_oe_n  <= (st_nx != S_READ);
      mem_we_n  <= (st_nx != S_WPUL);
      mem_dq_oe <= (st_nx inside {S_WSET, S_WPUL, S_WHLD});
      req_ready <= (st_nx == S_IDLE);
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  logic [CNT_W-1:0] chk_we_lo, chk_oe_lo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_we_lo <= '0;
      chk_oe_lo <= '0;
    end else begin
      chk_we_lo <= mem_we_n ? '0 : chk_we_lo + 1'b1;
      chk_oe_lo <= mem_oe_n ? '0 : chk_oe_lo + 1'b1;
    end
  end

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> $stable(mem_addr));
  a_r2_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_ce_n && mem_we_n && mem_oe_n));
  a_r3_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (chk_oe_lo == CNT_W'(RD_CYC)));
  a_r3_read_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_oe_n && $past(!mem_oe_n)) ##1 !rd_valid);
  a_r5_drive_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe));
  a_r5_drive_trail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (chk_we_lo == CNT_W'(WR_CYC)));
  a_r6_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  a_r6_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int RDC = 3, WRC = 3, TNC = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;

  always #2 clk = ~clk;

  asram_ctrl #(.ADDR_W(18), .DATA_W(8), .RD_CYC(RDC), .WR_CYC(WRC), .TURN_CYC(TNC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic [7:0] mem [256];
  logic       mem_drv;
  assign mem_drv   = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = mem_drv ? mem[mem_addr[7:0]] : 8'hzz;
  always @(posedge mem_we_n)
    if (!mem_ce_n) mem[mem_addr[7:0]] <= mem_dq_oe ? mem_dq_out : 8'hxx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && mem_dq_oe && mem_drv) chk(0, "R6 bus contention", 1, 0);

  localparam logic [26:0] VEC [8] = '{
    {1'b1, 18'h00000, 8'hA5}, {1'b1, 18'h3FFFF, 8'h5A},
    {1'b1, 18'h12345, 8'h3C}, {1'b0, 18'h00000, 8'hA5},
    {1'b0, 18'h3FFFF, 8'h5A}, {1'b1, 18'h00000, 8'hFF},
    {1'b0, 18'h12345, 8'h3C}, {1'b0, 18'h00000, 8'hFF}};

  task automatic run(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit poke);
    int k = 0, ce = 0, oe = 0, we = 0, drv = 0, quiet = 0, vidx = 0, vcnt = 0, bad_dq = 0;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    chk(req_ready, "R7 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && k < 50) begin
      k++;
      if (!mem_ce_n) ce++;
      if (!mem_oe_n) oe++;
      if (!mem_we_n) we++;
      if (mem_dq_oe) begin drv++; if (mem_dq_out != d) bad_dq++; end
      if (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe) quiet++;
      if (rd_valid) begin vcnt++; vidx = k; got = rd_data; end
      if (poke && k == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00045; req_wdata = 8'hEE;
      end
      if (poke && k == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    if (rd_valid) vcnt++;
    if (wr) begin
      chk(k == WRC + TNC + 3, "R8 write busy length", k, WRC + TNC + 3);
      chk(we == WRC, "R5 write strobe low cycles", we, WRC);
      chk(drv == WRC + 2, "R5 driver on cycles", drv, WRC + 2);
      chk(oe == 0, "R5 read strobe stays high", oe, 0);
      chk(bad_dq == 0, "R5 driven value", bad_dq, 0);
      chk(ce == WRC + 2, "R6 chip select cycles on write", ce, WRC + 2);
      chk(mem[a[7:0]] == d, "R5 byte stored", mem[a[7:0]], d);
    end else begin
      chk(k == RDC + TNC + 1, "R8 read busy length", k, RDC + TNC + 1);
      chk(oe == RDC && ce == RDC, "R3 read window cycles", oe, RDC);
      chk(we == 0 && drv == 0, "R3 no write, no drive", we + drv, 0);
      chk(vcnt == 1, "R4 single valid pulse", vcnt, 1);
      chk(vidx == RDC + 2, "R4 valid cycle", vidx, RDC + 2);
      chk(got == d, "R4 load data", got, d);
    end
    chk(quiet == TNC + 1, "R2 R8 all-high cycles", quiet, TNC + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
        "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && req_ready, "R1 after release", {mem_ce_n, mem_we_n, req_ready}, 3'b111);

    for (int i = 0; i < 8; i++) run(VEC[i][26], VEC[i][25:8], VEC[i][7:0], 1'b0);

    run(1'b0, 18'h12345, 8'h3C, 1'b1);
    @(negedge clk);
    chk(mem_ce_n && req_ready, "R7 busy request ignored", mem_ce_n, 1);
    run(1'b0, 18'h12345, 8'h3C, 1'b0);
    chk(mem[8'h45] == 8'h3C, "R7 memory untouched by ignored request", mem[8'h45], 8'h3C);

    run(1'b1, 18'h000AA, 8'h00, 1'b0);
    run(1'b0, 18'h000AA, 8'h00, 1'b0);
    run(1'b1, 18'h000AA, 8'hC3, 1'b0);
    run(1'b0, 18'h000AA, 8'hC3, 1'b0);

    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00010; req_wdata = 8'h77;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_we_n, "R5 inside write pulse before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
        "R1 reset mid-access", {mem_ce_n, mem_we_n, mem_dq_oe, req_ready}, 4'b1101);
    @(negedge clk); rst_n = 1'b1;
    run(1'b1, 18'h00011, 8'h99, 1'b0);
    run(1'b0, 18'h00011, 8'h99, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule